// File: doc/BRIEF.md
# Word-Wide Stack Pointer Unit

This block owns the stack pointer of a downward-growing stack that lives inside one 64 KByte segment. A client asks it to push or pop one 16-bit word. The unit moves the pointer and drives a byte-wide memory port in the right order for each command. A push lowers the pointer by one word before it writes the two bytes. A pop reads the two bytes at the current top and only then raises the pointer. The stack segment value comes in on a port. Each byte address is that segment shifted left by four bits plus the byte offset. Offsets wrap inside the 16-bit segment range, and physical addresses wrap inside the 20-bit space.

A word is stored little-endian: the low byte goes to the pointer offset and the high byte to the offset plus one. The memory port is synchronous. A read strobe in one cycle returns its byte on `mem_rdata` in the next cycle. While a command is in progress the unit is busy and ignores every command. A single-cycle `done` pulse marks the cycle after the last memory access of a command. When idle, a pointer-load command replaces the pointer with a given value. A push and a pop asserted together are refused, and the refusal is shown by a one-cycle error pulse.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads FFFEh, and `busy`, `done`, `cmd_err`, `mem_wr` and `mem_rd` are all 0.
- R2: An accepted push lowers the pointer by 2 in the cycle it is taken. In the two following cycles `mem_wr` is high, first with the low byte of the push word at the new offset, then with the high byte at the new offset plus 1. The pointer does not change during the writes.
- R3: An accepted pop drives `mem_rd` for two cycles, at the current offset and then at the offset plus 1, while the pointer holds still. After the last byte is captured the pointer rises by 2. `pop_data` holds the word assembled with the first byte read as its low byte.
- R4: Every memory address equals segment×16 + byte offset, taken modulo 2^20. The byte offset (pointer, or pointer+1) is taken modulo 2^16.
- R5: Words leave in reverse order of arrival: a run of pops returns the pushed words last-first.
- R6: Pointer arithmetic wraps modulo 2^16: a push at offset 0000h writes at FFFEh/FFFFh and leaves FFFEh, and a pop at FFFEh reads FFFEh/FFFFh and leaves 0000h.
- R7: When `cmd_push` and `cmd_pop` are high together while idle, `cmd_err` pulses high for one cycle one clock later. No memory strobe follows, and the pointer is unchanged.
- R8: `done` is high for exactly one cycle. For a push it rises 2 cycles after the accepting edge, and for a pop 3 cycles after it. `busy` is high from the cycle after acceptance through the `done` cycle.
- R9: Any push, pop or load command given while `busy` is high has no effect on the pointer, the memory or `pop_data`.
- R10: While idle with neither push nor pop asserted, `cmd_load` sets the pointer to `load_val` at the next edge. A load given together with a push or a pop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_base | input | 16 | Stack segment value |
| cmd_push | input | 1 | Push command |
| cmd_pop | input | 1 | Pop command |
| cmd_load | input | 1 | Pointer-load command |
| load_val | input | 16 | New pointer value for a load |
| push_data | input | 16 | Word to push, sampled when the push is accepted |
| pop_data | output | 16 | Last word popped |
| sp_out | output | 16 | Current stack pointer |
| mem_addr | output | 20 | Byte address to memory |
| mem_wr | output | 1 | Byte write strobe |
| mem_rd | output | 1 | Byte read strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the cycle after `mem_rd` |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | One-cycle pulse for a refused push and pop pair |

## Verification
The bench goes after the offset wrap at both ends of the segment. A design that carried the offset into the segment part would write to the wrong 64 KByte region. The bench also tests a high segment whose physical sum overflows 20 bits, where a wrong width would address outside the space. Pushes followed by pops check the pre-decrement and post-increment order. A design that swapped these would read back a neighbouring word or leave the pointer one word off. Commands injected while busy, and push and pop given together, show whether a design starts a second access or corrupts the pointer. Timing checks on `done` catch a design that ends before the last byte is read.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_READ  = 3'd2,
    ST_DRAIN = 3'd3,
    ST_FIN   = 3'd4
  } stk_state_e;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int OFS_W = 16,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_en,
  input  logic             inc_en,
  input  logic             load_en,
  input  logic [OFS_W-1:0] load_val,
  output logic [OFS_W-1:0] sp
);
  localparam logic [OFS_W-1:0] STEP_V  = OFS_W'(STEP);
  localparam logic [OFS_W-1:0] RESET_V = '0 - STEP_V;

  logic [OFS_W-1:0] sp_q, sp_d;
  logic             sp_en;

  always_comb begin
    sp_en = dec_en | inc_en | load_en;
    sp_d  = sp_q;
    if (dec_en)       sp_d = sp_q - STEP_V;
    else if (inc_en)  sp_d = sp_q + STEP_V;
    else if (load_en) sp_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= RESET_V;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp = sp_q;

  // R6: a decrement from zero lands on the top of the segment
  a_r6_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && sp_q == '0) |=> (sp_q == RESET_V));
endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen #(
  parameter int SEG_W     = 16,
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic [SEG_W-1:0]           seg,
  input  logic [OFS_W-1:0]           ofs,
  output logic [SEG_W+SEG_SHIFT-1:0] phys
);
  localparam int PHYS_W = SEG_W + SEG_SHIFT;

  logic [PHYS_W-1:0] seg_part;
  logic [PHYS_W-1:0] ofs_part;

  always_comb begin
    seg_part = {seg, {SEG_SHIFT{1'b0}}};
    ofs_part = PHYS_W'(ofs);
    phys     = seg_part + ofs_part;
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int NBYTES = 2,
  parameter int IDX_W  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             load_req,
  output logic             acc_push,
  output logic             acc_pop,
  output logic             acc_load,
  output logic             wr_en,
  output logic             rd_en,
  output logic [IDX_W-1:0] idx,
  output logic             cap_en,
  output logic [IDX_W-1:0] cap_idx,
  output logic             sp_inc,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

  stk_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             cap_q, cap_d;
  logic [IDX_W-1:0] cidx_q;
  logic             err_q, err_d;
  logic             idle;

  always_comb begin
    idle     = (st_q == ST_IDLE);
    acc_push = idle & push_req & ~pop_req;
    acc_pop  = idle & pop_req & ~push_req;
    acc_load = idle & load_req & ~push_req & ~pop_req;
    err_d    = idle & push_req & pop_req;
    cap_d    = (st_q == ST_READ);
    st_d     = st_q;
    idx_d    = idx_q;
    unique case (st_q)
      ST_IDLE: begin
        idx_d = '0;
        if (acc_push)     st_d = ST_WRITE;
        else if (acc_pop) st_d = ST_READ;
      end
      ST_WRITE: begin
        if (idx_q == LAST) st_d = ST_FIN;
        else               idx_d = idx_q + 1'b1;
      end
      ST_READ: begin
        if (idx_q == LAST) st_d = ST_DRAIN;
        else               idx_d = idx_q + 1'b1;
      end
      ST_DRAIN: st_d = ST_FIN;
      ST_FIN:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      cap_q  <= 1'b0;
      cidx_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      cap_q  <= cap_d;
      cidx_q <= idx_q;
      err_q  <= err_d;
    end
  end

  assign wr_en   = (st_q == ST_WRITE);
  assign rd_en   = (st_q == ST_READ);
  assign idx     = idx_q;
  assign cap_en  = cap_q;
  assign cap_idx = cidx_q;
  assign sp_inc  = (st_q == ST_DRAIN);
  assign busy    = ~idle;
  assign done    = (st_q == ST_FIN);
  assign err     = err_q;

  // R8: completion pulse lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: completion follows a write or the final read capture
  a_r8_done_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_en) || $past(cap_en)));
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int SEG_W     = 16,
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int DATA_W    = 16,
  parameter int BYTE_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SEG_W-1:0]           seg_base,
  input  logic                       cmd_push,
  input  logic                       cmd_pop,
  input  logic                       cmd_load,
  input  logic [OFS_W-1:0]           load_val,
  input  logic [DATA_W-1:0]          push_data,
  output logic [DATA_W-1:0]          pop_data,
  output logic [OFS_W-1:0]           sp_out,
  output logic [SEG_W+SEG_SHIFT-1:0] mem_addr,
  output logic                       mem_wr,
  output logic                       mem_rd,
  output logic [BYTE_W-1:0]          mem_wdata,
  input  logic [BYTE_W-1:0]          mem_rdata,
  output logic                       busy,
  output logic                       done,
  output logic                       cmd_err
);
  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic             acc_push, acc_pop, acc_load;
  logic             wr_en, rd_en, cap_en, sp_inc;
  logic [IDX_W-1:0] idx, cap_idx;
  logic [OFS_W-1:0] sp_q;
  logic [OFS_W-1:0] cur_ofs;

  stk_seq #(.NBYTES(NBYTES), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .push_req(cmd_push), .pop_req(cmd_pop), .load_req(cmd_load),
    .acc_push(acc_push), .acc_pop(acc_pop), .acc_load(acc_load),
    .wr_en(wr_en), .rd_en(rd_en), .idx(idx),
    .cap_en(cap_en), .cap_idx(cap_idx), .sp_inc(sp_inc),
    .busy(busy), .done(done), .err(cmd_err)
  );

  stk_ptr #(.OFS_W(OFS_W), .STEP(NBYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .dec_en(acc_push), .inc_en(sp_inc), .load_en(acc_load),
    .load_val(load_val), .sp(sp_q)
  );

  assign cur_ofs = sp_q + OFS_W'(idx);

  stk_addr_gen #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_addr (
    .seg(seg_base), .ofs(cur_ofs), .phys(mem_addr)
  );

  // write word latched at acceptance
  logic [DATA_W-1:0] wbuf_q, wbuf_d;
  always_comb wbuf_d = acc_push ? push_data : wbuf_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wbuf_q <= '0;
    else        wbuf_q <= wbuf_d;
  end

  assign mem_wdata = wbuf_q[int'(idx)*BYTE_W +: BYTE_W];
  assign mem_wr    = wr_en;
  assign mem_rd    = rd_en;
  assign sp_out    = sp_q;

  // read word assembled byte by byte, lowest address in lowest byte
  logic [BYTE_W-1:0] rbuf_q [NBYTES];
  for (genvar b = 0; b < NBYTES; b++) begin : g_rbyte
    logic cap_here;
    assign cap_here = cap_en && (cap_idx == IDX_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rbuf_q[b] <= '0;
      else if (cap_here) rbuf_q[b] <= mem_rdata;
    end
    assign pop_data[b*BYTE_W +: BYTE_W] = rbuf_q[b];
  end

  // R2: pointer stays put across and right after each write
  a_r2_sp_stable_wr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> $stable(sp_q));

  // R3: pointer has not moved yet while the word is being read
  a_r3_sp_stable_rd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> $stable(sp_q));

  // R4: consecutive reads step one byte inside the segment
  a_r4_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (cur_ofs == $past(cur_ofs) + 1'b1));

  // R7: a refused pair produces no access and no pointer move
  a_r7_conflict_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (!mem_wr && !mem_rd && $stable(sp_q)));
endmodule

// File: tb/test_stack_ptr_unit.sv
module test_stack_ptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] seg_base = 16'h0000;
  logic        cmd_push = 1'b0, cmd_pop = 1'b0, cmd_load = 1'b0;
  logic [15:0] load_val = 16'h0000, push_data = 16'h0000;
  logic [15:0] pop_data, sp_out;
  logic [19:0] mem_addr;
  logic        mem_wr, mem_rd, busy, done, cmd_err;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  stack_ptr_unit i_stack_ptr_unit (
    .clk(clk), .rst_n(rst_n), .seg_base(seg_base),
    .cmd_push(cmd_push), .cmd_pop(cmd_pop), .cmd_load(cmd_load),
    .load_val(load_val), .push_data(push_data), .pop_data(pop_data),
    .sp_out(sp_out), .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .cmd_err(cmd_err)
  );

  // byte memory model, synchronous read
  logic [7:0] bmem [int];
  always @(posedge clk) begin
    if (mem_wr) bmem[int'(mem_addr)] = mem_wdata;
    if (mem_rd) mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 8'h00;
  end

  // reference state
  logic [7:0]  rmem [int];
  logic [15:0] ref_sp;

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  function automatic logic [7:0] rbyte(input logic [19:0] a);
    return rmem.exists(int'(a)) ? rmem[int'(a)] : 8'h00;
  endfunction

  function automatic logic [7:0] mbyte(input logic [19:0] a);
    return bmem.exists(int'(a)) ? bmem[int'(a)] : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_push(input logic [15:0] d);
    logic [15:0] nsp;
    int lat;
    nsp = ref_sp - 16'd2;
    @(negedge clk); cmd_push = 1'b1; push_data = d;
    @(negedge clk); cmd_push = 1'b0; push_data = ~d;
    chk("R2 sp pre-decremented", sp_out, nsp);
    chk("R2 write lo strobe", mem_wr, 1);
    chk("R4 write lo addr", mem_addr, phys(seg_base, nsp));
    chk("R2 write lo data", mem_wdata, d[7:0]);
    @(negedge clk);
    chk("R2 write hi strobe", mem_wr, 1);
    chk("R4 write hi addr", mem_addr, phys(seg_base, nsp + 16'd1));
    chk("R2 write hi data", mem_wdata, d[15:8]);
    chk("R8 busy during push", busy, 1);
    @(negedge clk);
    chk("R8 push done at 2", done, 1);
    chk("R2 no write in done cycle", mem_wr, 0);
    @(negedge clk);
    chk("R8 done single", done, 0);
    chk("R8 idle after push", busy, 0);
    ref_sp = nsp;
    rmem[int'(phys(seg_base, nsp))] = d[7:0];
    rmem[int'(phys(seg_base, nsp + 16'd1))] = d[15:8];
    chk("R2 memory lo", mbyte(phys(seg_base, nsp)), d[7:0]);
    chk("R2 memory hi", mbyte(phys(seg_base, nsp + 16'd1)), d[15:8]);
    lat = 0;
  endtask

  task automatic do_pop(output logic [15:0] got);
    logic [15:0] exp;
    exp = {rbyte(phys(seg_base, ref_sp + 16'd1)), rbyte(phys(seg_base, ref_sp))};
    @(negedge clk); cmd_pop = 1'b1;
    @(negedge clk); cmd_pop = 1'b0;
    chk("R3 read lo strobe", mem_rd, 1);
    chk("R4 read lo addr", mem_addr, phys(seg_base, ref_sp));
    chk("R3 sp held during read", sp_out, ref_sp);
    @(negedge clk);
    chk("R4 read hi addr", mem_addr, phys(seg_base, ref_sp + 16'd1));
    @(negedge clk);
    chk("R8 not done before last capture", done, 0);
    @(negedge clk);
    chk("R8 pop done at 3", done, 1);
    ref_sp = ref_sp + 16'd2;
    chk("R3 sp post-incremented", sp_out, ref_sp);
    chk("R3 pop data", pop_data, exp);
    got = pop_data;
    @(negedge clk);
    chk("R8 done single pop", done, 0);
  endtask

  task automatic do_load(input logic [15:0] v);
    @(negedge clk); cmd_load = 1'b1; load_val = v;
    @(negedge clk); cmd_load = 1'b0;
    ref_sp = v;
    chk("R10 load", sp_out, v);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [15:0] w;
    logic [15:0] pushed [$];
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 sp reset", sp_out, 16'hFFFE);
    chk("R1 busy reset", busy, 0);
    chk("R1 done reset", done, 0);
    chk("R1 err reset", cmd_err, 0);
    chk("R1 strobes reset", {mem_wr, mem_rd}, 0);
    rst_n = 1'b1;
    ref_sp = 16'hFFFE;
    seg_base = 16'h1230;

    // R5: LIFO order
    do_push(16'hA1B2); do_push(16'hC3D4); do_push(16'h00FF);
    do_pop(w); chk("R5 lifo 1", w, 16'h00FF);
    do_pop(w); chk("R5 lifo 2", w, 16'hC3D4);
    do_pop(w); chk("R5 lifo 3", w, 16'hA1B2);
    chk("R5 back to bottom", sp_out, 16'hFFFE);

    // R6: wrap at bottom of offsets and at top
    do_load(16'h0000);
    do_push(16'h5A6B);
    chk("R6 wrapped push sp", sp_out, 16'hFFFE);
    do_pop(w);
    chk("R6 wrapped pop sp", sp_out, 16'h0000);
    chk("R6 wrapped pop data", w, 16'h5A6B);
    do_load(16'hFFFF);
    do_push(16'h1357);
    do_pop(w);
    chk("R6 odd pointer wrap data", w, 16'h1357);

    // R4: 20-bit physical wrap
    seg_base = 16'hFFFF;
    do_load(16'hFFFE);
    do_push(16'hBEEF);
    chk("R4 high segment wrap lo", mbyte(20'h0FFEC), 8'hEF);
    do_pop(w);
    chk("R4 high segment pop", w, 16'hBEEF);
    seg_base = 16'h0400;

    // R7: push and pop together
    do_load(16'h2000);
    @(negedge clk); cmd_push = 1'b1; cmd_pop = 1'b1; cmd_load = 1'b1; load_val = 16'h1111;
    @(negedge clk); cmd_push = 1'b0; cmd_pop = 1'b0; cmd_load = 1'b0;
    chk("R7 err pulse", cmd_err, 1);
    chk("R7 no strobe", {mem_wr, mem_rd}, 0);
    chk("R7 sp unchanged", sp_out, 16'h2000);
    chk("R10 load ignored with pair", sp_out, 16'h2000);
    @(negedge clk);
    chk("R7 err single", cmd_err, 0);
    chk("R7 still idle", busy, 0);

    // R10: load beside a push is ignored
    @(negedge clk); cmd_push = 1'b1; cmd_load = 1'b1; load_val = 16'h0100; push_data = 16'h4242;
    @(negedge clk); cmd_push = 1'b0; cmd_load = 1'b0;
    chk("R10 push wins over load", sp_out, 16'h1FFE);
    repeat (3) @(negedge clk);
    ref_sp = 16'h1FFE;
    rmem[int'(phys(seg_base, 16'h1FFE))] = 8'h42;
    rmem[int'(phys(seg_base, 16'h1FFF))] = 8'h42;

    // R9: commands while busy
    @(negedge clk); cmd_push = 1'b1; push_data = 16'h7788;
    @(negedge clk); cmd_push = 1'b0; cmd_pop = 1'b1;
    @(negedge clk); cmd_pop = 1'b0; cmd_load = 1'b1; load_val = 16'h0042;
    @(negedge clk); cmd_load = 1'b0; cmd_push = 1'b1; push_data = 16'h9999;
    chk("R9 done while cmd pushed", done, 1);
    @(negedge clk); cmd_push = 1'b0;
    chk("R9 sp after busy cmds", sp_out, 16'h1FFC);
    chk("R9 memory intact", mbyte(phys(seg_base, 16'h1FFC)), 8'h88);
    chk("R9 memory intact hi", mbyte(phys(seg_base, 16'h1FFD)), 8'h77);
    ref_sp = 16'h1FFC;
    rmem[int'(phys(seg_base, 16'h1FFC))] = 8'h88;
    rmem[int'(phys(seg_base, 16'h1FFD))] = 8'h77;
    do_pop(w); chk("R9 popped word", w, 16'h7788);

    // random mix against the queue model
    pushed.delete();
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 5 || pushed.size() == 0) begin
        logic [15:0] d;
        d = 16'($urandom);
        do_push(d);
        pushed.push_back(d);
      end else if (r < 9) begin
        logic [15:0] e;
        e = pushed.pop_back();
        do_pop(w);
        chk("R5 random lifo", w, e);
      end else begin
        seg_base = 16'($urandom);
        pushed.delete();
        do_load(16'($urandom));
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule